// File: doc/BRIEF.md
# Coprocessor Memory Window Decoder

This block sits between an 8-bit sound coprocessor and the rest of the chip. It splits the coprocessor's 16-bit address space into regions on address bits 15..13 and steers every access to one target: an 8 KB local RAM that appears twice, the register port of an FM synthesizer, a serially loaded bank register, a window onto the video chip, or a 32 KB banked window into the main CPU's 24-bit bus.

Local targets (RAM, FM, bank, unused space) finish in the cycle the strobe is seen, with ready high. A video or window access becomes a main-bus transfer. The coprocessor is stalled with ready low while a video DMA owns the main bus, while the request waits for a grant, and for a fixed number of wait cycles after the grant. These wait cycles model the cost of crossing onto the shared bus.

The coprocessor holds its strobe, address and write data until the cycle in which ready is high, then drops the strobe before the next clock edge. Local accesses therefore last one cycle.

Top module: `cpx_window_decoder`

## Requirements
- R1: Addresses 0x0000-0x3FFF select the local RAM with `ram_addr` = address bits 12..0, so 0x2000+n and n reach the same word. A write pulses `ram_we` with `ram_wdata` = write data. A read returns `ram_rdata`. Ready stays high.
- R2: Addresses 0x4000-0x5FFF select the FM port with `fm_sel` = address bits 1..0. Writes pulse `fm_wr` and reads pulse `fm_rd`. A read returns `fm_rdata`. Ready stays high.
- R3: The bank register is 9 bits and resets to 0. A write to 0x6000-0x60FF shifts write-data bit 0 into bank bit 8 and moves the other bits one place down. The other data bits and all other accesses leave the bank unchanged.
- R4: An access to 0x8000-0xFFFF drives `mb_addr` = {bank[8:0], address bits 14..0}.
- R5: An access to 0x7F00-0x7FFF drives `mb_addr` = 0xC000 followed by address bits 7..0, giving 0xC000xx.
- R6: Reads of unused space (region 3 outside 0x7F00-0x7FFF, including reads of the bank range) return 0xFF with ready high. Unused writes pulse no target strobe and do not change the bank. At most one of `ram_we`, `fm_wr`, `fm_rd`, `mb_req` and the bank load is active in a cycle.
- R7: `mb_req` is never high while `dma_busy` is high. A main-bus access that starts during DMA raises its request only after DMA ends.
- R8: From the first cycle of a main-bus access, ready stays low. It returns high exactly WAIT_CYCLES+1 cycles after the cycle in which `mb_req` and `mb_gnt` are both high, and it stays high for one cycle only.
- R9: While requesting, `mb_we` equals the access direction and `mb_wdata` equals the write data. A read returns the `mb_rdata` value captured in the grant cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cp_addr | input | 16 | Coprocessor address |
| cp_wdata | input | 8 | Coprocessor write data |
| cp_rd | input | 1 | Read strobe |
| cp_wr | input | 1 | Write strobe |
| cp_rdata | output | 8 | Read data to coprocessor |
| cp_ready | output | 1 | High when the current access completes |
| ram_addr | output | 13 | Local RAM word index |
| ram_we | output | 1 | Local RAM write enable |
| ram_wdata | output | 8 | Local RAM write data |
| ram_rdata | input | 8 | Local RAM read data (combinational) |
| fm_sel | output | 2 | FM register port select |
| fm_wr | output | 1 | FM write strobe |
| fm_rd | output | 1 | FM read strobe |
| fm_wdata | output | 8 | FM write data |
| fm_rdata | input | 8 | FM read data |
| dma_busy | input | 1 | Video DMA owns the main bus |
| mb_req | output | 1 | Main-bus request |
| mb_addr | output | 24 | Main-bus byte address |
| mb_we | output | 1 | Main-bus write |
| mb_wdata | output | 8 | Main-bus write data |
| mb_gnt | input | 1 | Main-bus grant; completes the transfer |
| mb_rdata | input | 8 | Main-bus read data, valid with grant |

## Verification
The assertions assume that the coprocessor keeps its address and strobe steady from the start of an access until ready is high, and never raises read and write together. The stimulus enforces this by setting each access once and dropping it right after the sample in which ready is seen high. The slave model grants only while `mb_req` is high and at random delays. Random DMA bursts start and stop at arbitrary points around requests, which exercises the withdraw-and-retry path.

// File: rtl/cpx_pkg.sv
// Shared types for the coprocessor window decoder.
// Assumes: nothing beyond IEEE 1800-2017.
package cpx_pkg;

    // Target selected by one coprocessor address.
    typedef enum logic [2:0] {
        TGT_NONE,
        TGT_RAM,
        TGT_FM,
        TGT_BANK,
        TGT_VIDEO,
        TGT_WINDOW
    } cpx_tgt_e;

    // States of the main-bus transfer sequencer.
    typedef enum logic [2:0] {
        MS_IDLE,
        MS_DMA_WAIT,
        MS_REQ,
        MS_HOLD,
        MS_DONE
    } cpx_mstate_e;

endpackage

// File: rtl/cpx_addr_decode.sv
// Address decoder: maps a coprocessor address to a target and forms the
// main-bus address for the video and banked window regions.
// Assumes: CP_AW-1 equals MB_AW-BANK_W, so the window offset fills the
// space below the bank bits.
module cpx_addr_decode
    import cpx_pkg::*;
#(
    parameter int CP_AW      = 16,
    parameter int MB_AW      = 24,
    parameter int BANK_W     = 9,
    parameter logic [7:0] BANK_PAGE  = 8'h60,
    parameter logic [7:0] VIDEO_PAGE = 8'h7F,
    parameter logic [MB_AW-1:0] VIDEO_BASE = 24'hC00000
) (
    input  logic [CP_AW-1:0]  addr,
    input  logic [BANK_W-1:0] bank,
    output cpx_tgt_e          tgt,
    output logic [MB_AW-1:0]  mb_addr
);
    localparam int OFS_W  = MB_AW - BANK_W;
    localparam int REG_LO = CP_AW - 3;

    logic [2:0] region;
    logic [7:0] page;

    assign region = addr[CP_AW-1:REG_LO];
    assign page   = addr[CP_AW-1:CP_AW-8];

    // Pick the target from the region bits and, in region 3, the page.
    always_comb begin
        unique case (region)
            3'd0, 3'd1: tgt = TGT_RAM;
            3'd2:       tgt = TGT_FM;
            3'd3: begin
                if (page == BANK_PAGE)       tgt = TGT_BANK;
                else if (page == VIDEO_PAGE) tgt = TGT_VIDEO;
                else                         tgt = TGT_NONE;
            end
            default:    tgt = TGT_WINDOW;
        endcase
    end

    // Form the main-bus address: fixed video base or bank plus offset.
    always_comb begin
        if (tgt == TGT_VIDEO)
            mb_addr = {VIDEO_BASE[MB_AW-1:8], addr[7:0]};
        else
            mb_addr = {bank, addr[OFS_W-1:0]};
    end

endmodule

// File: rtl/cpx_bank_shift.sv
// Bank register: a serially loaded shift register that moves the new bit
// in at the top and shifts the rest down by one.
// Assumes: shift_en is high for one cycle per bank write.
module cpx_bank_shift #(
    parameter int BANK_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_en,
    input  logic              bit_in,
    output logic [BANK_W-1:0] bank
);
    logic [BANK_W-1:0] bank_q;

    // Shift one bit in at the top on each bank write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            bank_q <= '0;
        else if (shift_en)
            bank_q <= {bit_in, bank_q[BANK_W-1:1]};
    end

    assign bank = bank_q;

    p_bank_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_en |=> $stable(bank_q))
        else $error("bank changed without a bank write");

endmodule

// File: rtl/cpx_mbus_seq.sv
// Main-bus sequencer: waits out video DMA, requests the bus, captures read
// data on the grant, then counts WAIT_CYCLES before signalling completion.
// Assumes: start stays high from the first cycle of the access until done,
// WAIT_CYCLES >= 1, and mb_gnt completes the transfer in its cycle.
module cpx_mbus_seq
    import cpx_pkg::*;
#(
    parameter int DW          = 8,
    parameter int WAIT_CYCLES = 45
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          dma_busy,
    input  logic          mb_gnt,
    input  logic [DW-1:0] mb_rdata,
    output logic          mb_req,
    output logic          done,
    output logic [DW-1:0] rdata
);
    localparam int CW = $clog2(WAIT_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(WAIT_CYCLES - 1);

    cpx_mstate_e   state_q, state_d;
    logic [CW-1:0] cnt_q;
    logic [DW-1:0] rdata_q;

    // The request is withdrawn at once if DMA takes the bus.
    assign mb_req = (state_q == MS_REQ) && !dma_busy;
    assign done   = (state_q == MS_DONE);
    assign rdata  = rdata_q;

    // Next state of the transfer sequence.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MS_IDLE:     if (start) state_d = dma_busy ? MS_DMA_WAIT : MS_REQ;
            MS_DMA_WAIT: if (!dma_busy) state_d = MS_REQ;
            MS_REQ: begin
                if (dma_busy)    state_d = MS_DMA_WAIT;
                else if (mb_gnt) state_d = MS_HOLD;
            end
            MS_HOLD:     if (cnt_q == LAST) state_d = MS_DONE;
            MS_DONE:     state_d = MS_IDLE;
            default:     state_d = MS_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= MS_IDLE;
        else        state_q <= state_d;
    end

    // Wait counter, cleared on grant and advanced while holding.
    always_ff @(posedge clk) begin
        if (!rst_n)                       cnt_q <= '0;
        else if (mb_req && mb_gnt)        cnt_q <= '0;
        else if (state_q == MS_HOLD)      cnt_q <= cnt_q + 1'b1;
    end

    // Read data captured in the grant cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)                rdata_q <= '0;
        else if (mb_req && mb_gnt) rdata_q <= mb_rdata;
    end

    p_cnt_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == MS_HOLD) |-> (cnt_q <= LAST))
        else $error("wait counter past its limit");

    p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done)
        else $error("completion held for more than one cycle");

    p_hold_after_grant_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mb_req && mb_gnt) |=> (state_q == MS_HOLD && !mb_req))
        else $error("grant did not start the wait period");

endmodule

// File: rtl/cpx_window_decoder.sv
// Top: routes coprocessor accesses to RAM, FM port, bank register, video
// window or banked main-bus window, and stalls main-bus accesses with ready.
// Assumes: the coprocessor holds address, data and one strobe until the cycle
// in which cp_ready is high, then drops the strobe before the next edge.
module cpx_window_decoder
    import cpx_pkg::*;
#(
    parameter int CP_AW       = 16,
    parameter int DW          = 8,
    parameter int RAM_AW      = 13,
    parameter int FM_SW       = 2,
    parameter int BANK_W      = 9,
    parameter int MB_AW       = 24,
    parameter int WAIT_CYCLES = 45
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CP_AW-1:0]  cp_addr,
    input  logic [DW-1:0]     cp_wdata,
    input  logic              cp_rd,
    input  logic              cp_wr,
    output logic [DW-1:0]     cp_rdata,
    output logic              cp_ready,
    output logic [RAM_AW-1:0] ram_addr,
    output logic              ram_we,
    output logic [DW-1:0]     ram_wdata,
    input  logic [DW-1:0]     ram_rdata,
    output logic [FM_SW-1:0]  fm_sel,
    output logic              fm_wr,
    output logic              fm_rd,
    output logic [DW-1:0]     fm_wdata,
    input  logic [DW-1:0]     fm_rdata,
    input  logic              dma_busy,
    output logic              mb_req,
    output logic [MB_AW-1:0]  mb_addr,
    output logic              mb_we,
    output logic [DW-1:0]     mb_wdata,
    input  logic              mb_gnt,
    input  logic [DW-1:0]     mb_rdata
);
    localparam logic [DW-1:0] OPEN_BUS = '1;

    cpx_tgt_e          tgt;
    logic [BANK_W-1:0] bank;
    logic              bank_we;
    logic              is_mb;
    logic              mb_start;
    logic              seq_done;
    logic [DW-1:0]     seq_rdata;

    cpx_addr_decode #(
        .CP_AW (CP_AW),
        .MB_AW (MB_AW),
        .BANK_W(BANK_W)
    ) u_decode (
        .addr   (cp_addr),
        .bank   (bank),
        .tgt    (tgt),
        .mb_addr(mb_addr)
    );

    cpx_bank_shift #(
        .BANK_W(BANK_W)
    ) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .shift_en(bank_we),
        .bit_in  (cp_wdata[0]),
        .bank    (bank)
    );

    cpx_mbus_seq #(
        .DW         (DW),
        .WAIT_CYCLES(WAIT_CYCLES)
    ) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (mb_start),
        .dma_busy(dma_busy),
        .mb_gnt  (mb_gnt),
        .mb_rdata(mb_rdata),
        .mb_req  (mb_req),
        .done    (seq_done),
        .rdata   (seq_rdata)
    );

    // Target strobes and pass-through data paths.
    always_comb begin
        ram_addr  = cp_addr[RAM_AW-1:0];
        ram_wdata = cp_wdata;
        ram_we    = cp_wr && (tgt == TGT_RAM);
        fm_sel    = cp_addr[FM_SW-1:0];
        fm_wdata  = cp_wdata;
        fm_wr     = cp_wr && (tgt == TGT_FM);
        fm_rd     = cp_rd && (tgt == TGT_FM);
        bank_we   = cp_wr && (tgt == TGT_BANK);
        is_mb     = (tgt == TGT_VIDEO) || (tgt == TGT_WINDOW);
        mb_start  = (cp_rd || cp_wr) && is_mb;
        mb_we     = cp_wr;
        mb_wdata  = cp_wdata;
    end

    // Read data multiplexer and ready generation.
    always_comb begin
        unique case (tgt)
            TGT_RAM:                cp_rdata = ram_rdata;
            TGT_FM:                 cp_rdata = fm_rdata;
            TGT_VIDEO, TGT_WINDOW:  cp_rdata = seq_rdata;
            default:                cp_rdata = OPEN_BUS;
        endcase
        cp_ready = mb_start ? seq_done : 1'b1;
    end

    p_one_target_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ram_we, fm_wr, fm_rd, mb_req, bank_we}))
        else $error("more than one target strobed");

    p_stall_on_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mb_req |-> !cp_ready)
        else $error("ready high while the main bus is requested");

    p_no_req_in_dma_r7: assert property (@(posedge clk) disable iff (!rst_n)
        dma_busy |-> !mb_req)
        else $error("main-bus request during DMA");

    p_addr_steady_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mb_req && !mb_gnt) |=> (!mb_req || $stable(mb_addr)))
        else $error("main-bus address moved during a pending request");

endmodule

// File: tb/cpx_window_decoder_tb_top.sv
module cpx_window_decoder_tb_top;
    localparam int WAITC = 45;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cp_addr = '0;
    logic [7:0]  cp_wdata = '0;
    logic        cp_rd = 1'b0;
    logic        cp_wr = 1'b0;
    logic [7:0]  cp_rdata;
    logic        cp_ready;
    logic [12:0] ram_addr;
    logic        ram_we;
    logic [7:0]  ram_wdata;
    logic [7:0]  ram_rdata;
    logic [1:0]  fm_sel;
    logic        fm_wr, fm_rd;
    logic [7:0]  fm_wdata;
    logic [7:0]  fm_rdata;
    logic        dma_busy = 1'b0;
    logic        mb_req;
    logic [23:0] mb_addr;
    logic        mb_we;
    logic [7:0]  mb_wdata;
    logic        mb_gnt = 1'b0;
    logic [7:0]  mb_rdata;

    int total = 0;
    int bad = 0;
    bit finished = 0;
    bit dma_rand = 0;
    logic [8:0] exp_bank = '0;

    always #10 clk = ~clk;

    cpx_window_decoder #(.WAIT_CYCLES(WAITC)) dut_i (
        .clk(clk), .rst_n(rst_n), .cp_addr(cp_addr), .cp_wdata(cp_wdata),
        .cp_rd(cp_rd), .cp_wr(cp_wr), .cp_rdata(cp_rdata), .cp_ready(cp_ready),
        .ram_addr(ram_addr), .ram_we(ram_we), .ram_wdata(ram_wdata),
        .ram_rdata(ram_rdata), .fm_sel(fm_sel), .fm_wr(fm_wr), .fm_rd(fm_rd),
        .fm_wdata(fm_wdata), .fm_rdata(fm_rdata), .dma_busy(dma_busy),
        .mb_req(mb_req), .mb_addr(mb_addr), .mb_we(mb_we), .mb_wdata(mb_wdata),
        .mb_gnt(mb_gnt), .mb_rdata(mb_rdata)
    );

    function automatic logic [7:0] ram_fn(input logic [12:0] a);
        return a[7:0] ^ {3'b0, a[12:8]} ^ 8'h3C;
    endfunction
    function automatic logic [7:0] fm_fn(input logic [1:0] s);
        return 8'h50 + {6'b0, s};
    endfunction
    function automatic logic [7:0] slave_fn(input logic [23:0] a);
        return a[7:0] ^ a[15:8] ^ a[23:16] ^ 8'hA5;
    endfunction
    function automatic logic [23:0] exp_mb(input logic [15:0] a, input logic [8:0] b);
        if (a[15:8] == 8'h7F) return {16'hC000, a[7:0]};
        return {b, a[14:0]};
    endfunction

    assign ram_rdata = ram_fn(ram_addr);
    assign fm_rdata  = fm_fn(fm_sel);
    assign mb_rdata  = slave_fn(mb_addr);

    // Slave: grants a pending request at random.
    always @(negedge clk) begin
        #2;
        mb_gnt = mb_req && ($urandom % 3 == 0);
    end

    // Random DMA bursts when enabled.
    always @(negedge clk) begin
        if (dma_rand) begin
            if (dma_busy) dma_busy = ($urandom % 4 != 0);
            else          dma_busy = ($urandom % 8 == 0);
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One-cycle local access; samples outputs inside the cycle.
    task automatic local_acc(input logic [15:0] a, input bit we, input logic [7:0] d,
                             output logic [7:0] rd);
        @(negedge clk);
        cp_addr = a; cp_wdata = d; cp_wr = we; cp_rd = !we;
        #3;
        rd = cp_rdata;
        chk(cp_ready === 1'b1, "R1/R2/R6 ready", {31'b0, cp_ready}, 1);
        @(negedge clk);
        cp_wr = 0; cp_rd = 0;
        if (we && a[15:8] == 8'h60) exp_bank = {d[0], exp_bank[8:1]};
    endtask

    // Main-bus access; checks stall, address, data and wait count.
    task automatic mb_acc(input logic [15:0] a, input bit we, input logic [7:0] d);
        bit granted = 0;
        int k = 0;
        logic [23:0] ea = exp_mb(a, exp_bank);
        @(negedge clk);
        cp_addr = a; cp_wdata = d; cp_wr = we; cp_rd = !we;
        #3;
        chk(cp_ready === 1'b0, "R8 first cycle stalled", {31'b0, cp_ready}, 0);
        for (int i = 0; i < 2000; i++) begin
            if (dma_busy && mb_req) chk(0, "R7 request during DMA", 1, 0);
            if (mb_req && mb_gnt) begin
                granted = 1; k = 0;
                chk(mb_addr === ea, (a[15] ? "R4 window address" : "R5 video address"),
                    mb_addr, ea);
                chk(mb_we === we && (!we || mb_wdata === d), "R9 direction/data",
                    {mb_we, mb_wdata}, {we, d});
            end else if (granted) k++;
            if (cp_ready) begin
                chk(granted && k == WAITC + 1, "R8 wait length", k, WAITC + 1);
                if (!we) chk(cp_rdata === slave_fn(ea), "R9 read data", cp_rdata, slave_fn(ea));
                cp_wr = 0; cp_rd = 0;
                return;
            end
            @(negedge clk); #3;
        end
        chk(0, "R8 access never completed", 0, 1);
        cp_wr = 0; cp_rd = 0;
    endtask

    task automatic bank_load(input logic [8:0] v);
        logic [7:0] r;
        for (int i = 0; i < 9; i++) local_acc(16'h6000 + 16'(i), 1'b1, {7'h7F, v[i]}, r);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            chk(0, "watchdog expired", 0, 1);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] r;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1;
        #3;
        chk(cp_ready === 1 && mb_req === 0, "R8 reset idle", {cp_ready, mb_req}, 2);

        // Reset bank is zero: window address is plain offset (R3, R4).
        mb_acc(16'h8123, 1'b0, 8'h00);

        // RAM mirroring (R1).
        local_acc(16'h0155, 1'b0, 0, r);
        chk(r === ram_fn(13'h0155), "R1 RAM read", r, ram_fn(13'h0155));
        local_acc(16'h2155, 1'b0, 0, r);
        chk(r === ram_fn(13'h0155), "R1 mirror read", r, ram_fn(13'h0155));
        @(negedge clk);
        cp_addr = 16'h3FFF; cp_wdata = 8'h77; cp_wr = 1; #3;
        chk(ram_we === 1 && ram_addr === 13'h1FFF && ram_wdata === 8'h77,
            "R1 RAM write", {ram_we, ram_addr}, {1'b1, 13'h1FFF});
        @(negedge clk); cp_wr = 0;

        // FM port (R2).
        @(negedge clk);
        cp_addr = 16'h5FFE; cp_wdata = 8'h12; cp_wr = 1; #3;
        chk(fm_wr === 1 && fm_sel === 2'd2 && fm_wdata === 8'h12, "R2 FM write",
            {fm_wr, fm_sel}, {1'b1, 2'd2});
        @(negedge clk); cp_wr = 0;
        local_acc(16'h4003, 1'b0, 0, r);
        chk(r === fm_fn(2'd3), "R2 FM read", r, fm_fn(2'd3));

        // Unused space (R6).
        local_acc(16'h6500, 1'b0, 0, r);
        chk(r === 8'hFF, "R6 unused read", r, 8'hFF);
        local_acc(16'h6010, 1'b0, 0, r);
        chk(r === 8'hFF, "R6 bank-range read", r, 8'hFF);
        @(negedge clk);
        cp_addr = 16'h7E00; cp_wdata = 8'hFF; cp_wr = 1; #3;
        chk({ram_we, fm_wr, fm_rd, mb_req} === 4'b0, "R6 unused write no strobe",
            {ram_we, fm_wr, fm_rd, mb_req}, 0);
        @(negedge clk); cp_wr = 0;
        mb_acc(16'h8000, 1'b0, 0);   // bank still zero after unused write (R6, R3)

        // Bank loading sequence and window addresses (R3, R4).
        bank_load(9'h1A5);
        mb_acc(16'hFFFF, 1'b0, 0);
        local_acc(16'h60FF, 1'b1, 8'hFE, r);  // only bit 0 used (R3)
        mb_acc(16'h9234, 1'b1, 8'h5A);
        bank_load(9'h001);
        mb_acc(16'hC000, 1'b0, 0);
        bank_load(9'h100);
        mb_acc(16'h8001, 1'b1, 8'h3C);

        // Video window (R5).
        mb_acc(16'h7F04, 1'b0, 0);
        mb_acc(16'h7FFF, 1'b1, 8'h99);

        // DMA in progress at access start (R7).
        @(negedge clk); dma_busy = 1;
        fork
            mb_acc(16'hA000, 1'b0, 0);
            begin repeat (12) @(negedge clk); #1; dma_busy = 0; end
        join

        // Random mix with DMA bursts.
        dma_rand = 1;
        for (int n = 0; n < 80; n++) begin
            logic [15:0] a = 16'($urandom);
            logic [7:0]  d = 8'($urandom);
            int kind = $urandom % 6;
            case (kind)
                0: begin
                    a[15:14] = 2'b00;
                    local_acc(a, 1'b0, 0, r);
                    chk(r === ram_fn(a[12:0]), "R1 random RAM", r, ram_fn(a[12:0]));
                end
                1: begin
                    a[15:13] = 3'd2;
                    local_acc(a, 1'b0, 0, r);
                    chk(r === fm_fn(a[1:0]), "R2 random FM", r, fm_fn(a[1:0]));
                end
                2: begin
                    a[15:8] = 8'h60;
                    local_acc(a, 1'b1, d, r);
                end
                3: begin
                    a[15:8] = 8'h7F;
                    mb_acc(a, d[0], d);
                end
                default: begin
                    a[15] = 1'b1;
                    mb_acc(a, d[0], d);
                end
            endcase
        end
        dma_rand = 0; dma_busy = 0;

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule